// File: doc/BRIEF.md
# Chip-Select-Framed Serial ADC Output Emulator

This block plays the converter side of a three-wire serial link of the kind used by micro-power successive-approximation ADCs. A host lowers an active-low chip select, toggles a serial clock, and reads one frame from a serial data line. Each frame is four leading zeros followed by the conversion result, most significant bit first. The result is taken from a parallel sample input that is assumed to be valid already. Alongside the data line the block drives an output-enable flag for an external tristate buffer, a track/hold flag and a powered-down flag. Together these show the state of the emulated converter.

The resolution parameter selects 8, 10 or 12 bits, and the frame is four clocks longer than the result. The first leading zero is presented as soon as chip select falls. Each later bit is launched on a serial-clock falling edge. Raising chip select ends the frame at any point. Chip select and serial clock are sampled on the system clock and must be synchronous to it. Every edge seen on a system-clock rising edge shows on the outputs right after that same edge. Reset is asynchronous on assertion and released on the system clock.

Top module: `adc_serial_emu`

## Requirements
- R1: After reset, with chip select high, `pdown`=1, `sdata_oe`=0, `track`=0 (0 means hold, 1 means track) and `sdata`=0.
- R2: On the clock edge that sees `cs_n` go from 1 to 0, the outputs become `sdata_oe`=1, `pdown`=0, `track`=1 and `sdata`=0, which is the first leading zero.
- R3: With F = RES_BITS+4, after the k-th falling edge of `sclk` (k from 1 to F-1) in a frame, `sdata` carries frame bit k. That bit is 0 for k<4 and `sample` bit RES_BITS-1-(k-4) for k of 4 or more. `sdata` changes only on those falling edges.
- R4: `track` drops to 0 on the third `sclk` falling edge of the frame and stays 0 for the rest of the frame.
- R5: On the F-th `sclk` falling edge, `sdata_oe` goes to 0 and `pdown` to 1. The LSB stays on `sdata` from edge F-1 until then.
- R6: When `cs_n` rises at any point in a frame, including in the same clock as an `sclk` falling edge, the outputs at the next clock edge are `sdata_oe`=0, `pdown`=1, `track`=0 and `sdata`=0.
- R7: After a frame completes, further `sclk` falling edges with `cs_n` still low change no output. A new frame starts only after `cs_n` goes high and then low again.
- R8: `sample` is captured on the third `sclk` falling edge. Any later change of `sample` does not alter the bits sent in that frame.
- R9: Whenever `cs_n` was high at the previous clock edge, `pdown`=1 and `sdata_oe`=0.
- R10: F is 16 for RES_BITS=12, 14 for RES_BITS=10 and 12 for RES_BITS=8.
- R11: `sdata` is 0 whenever `sdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; chip select and serial clock are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select that frames a transfer |
| sclk | input | 1 | Serial clock from the host; idles high, and bits launch on its falling edge |
| sample | input | RES_BITS | Parallel conversion result to be sent |
| sdata | output | 1 | Serial data bit; 0 while not driving |
| sdata_oe | output | 1 | 1 while the data line must be driven, 0 for high impedance |
| track | output | 1 | 1 while in track mode, 0 in hold |
| pdown | output | 1 | 1 while the emulated converter is powered down |

## Verification
On every clock, the assertions check the following properties. A chip-select fall produces the start-of-frame outputs, and a rise forces the powered-down, undriven state. Outputs move only when one of the two framing inputs has an edge. Track mode is entered only by a frame start. The line enable drops only because of a chip-select rise or a serial-clock fall. Some behaviour depends on how many serial-clock falls a frame has seen, and only the bench's scenarios can show it. This covers where the data bits fall, the hold point at the third edge, the frame length for each resolution, the late sample change and the ignored edges after the frame ends. The bench covers these with a per-clock behavioural model for all three resolutions, plus frame-level checks of the bit pattern and of aborts at several points.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

  // Phase of one chip-select framed transfer.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  // Number of zero bits ahead of the result in every frame.
  localparam int LEAD_ZEROS = 4;

  // Serial clock falling edge on which track/hold returns to hold.
  localparam int HOLD_EDGE = 3;

  // Falling edges in a complete frame for a given resolution.
  function automatic int frame_len(input int res_bits);
    return res_bits + LEAD_ZEROS;
  endfunction

endpackage

// File: rtl/adc_emu_rst_sync.sv
module adc_emu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/adc_emu_edge.sv
module adc_emu_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] fell,
  output logic [N-1:0] rose
);

  // Each line idles high, so the previous value resets to 1.
  for (genvar i = 0; i < N; i++) begin : g_line
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b1;
      end else begin
        prev_q <= din[i];
      end
    end

    assign fell[i] = prev_q & ~din[i];
    assign rose[i] = ~prev_q & din[i];
  end

endmodule

// File: rtl/adc_emu_seq.sv
module adc_emu_seq
  import adc_emu_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_fall,
  input  logic cs_rise,
  input  logic sc_fall,
  output logic load_word,
  output logic shift_word,
  output logic data_phase,
  output logic line_on,
  output logic tracking,
  output logic asleep
);

  localparam int FRAME_LEN = frame_len(RES_BITS);
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_HOLD = CNT_W'(HOLD_EDGE);
  localparam logic [CNT_W-1:0] CNT_LEAD = CNT_W'(LEAD_ZEROS);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             trk_q, trk_d;
  logic             upd_en;

  assign upd_en = cs_fall | cs_rise | sc_fall;

  always_comb begin
    ph_d       = ph_q;
    cnt_d      = cnt_q;
    trk_d      = trk_q;
    load_word  = 1'b0;
    shift_word = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (cs_fall) begin
          ph_d  = PH_RUN;
          cnt_d = '0;
          trk_d = 1'b1;
        end
      end
      PH_RUN: begin
        if (cs_rise) begin
          ph_d  = PH_IDLE;
          trk_d = 1'b0;
        end else if (sc_fall) begin
          cnt_d = cnt_q + CNT_ONE;
          if (cnt_d == CNT_HOLD) begin
            trk_d     = 1'b0;
            load_word = 1'b1;
          end
          if ((cnt_d > CNT_LEAD) && (cnt_d < CNT_LAST)) begin
            shift_word = 1'b1;
          end
          if (cnt_d == CNT_LAST) begin
            ph_d = PH_DONE;
          end
        end
      end
      PH_DONE: begin
        if (cs_rise) begin
          ph_d = PH_IDLE;
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        trk_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      trk_q <= 1'b0;
    end else if (upd_en) begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      trk_q <= trk_d;
    end
  end

  assign line_on    = (ph_q == PH_RUN);
  assign asleep     = (ph_q != PH_RUN);
  assign tracking   = trk_q;
  assign data_phase = (ph_q == PH_RUN) && (cnt_q >= CNT_LEAD);

endmodule

// File: rtl/adc_emu_word.sv
module adc_emu_word #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         msb
);

  logic [W-1:0] word_q, word_d;
  logic         word_en;

  assign word_en = load | shift;

  always_comb begin
    word_d = word_q;
    if (load) begin
      word_d = din;
    end else if (shift) begin
      word_d = {word_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  assign msb = word_q[W-1];

endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu #(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic [RES_BITS-1:0] sample,
  output logic                sdata,
  output logic                sdata_oe,
  output logic                track,
  output logic                pdown
);

  logic       rst_n_i;
  logic [1:0] fell_v, rose_v;
  logic       sclk_rise_unused;
  logic       load_w, shift_w, in_data, word_msb;

  adc_emu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  // bit 1: chip select, bit 0: serial clock
  adc_emu_edge #(.N(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_n_i),
    .din   ({cs_n, sclk}),
    .fell  (fell_v),
    .rose  (rose_v)
  );

  assign sclk_rise_unused = rose_v[0];

  adc_emu_seq #(.RES_BITS(RES_BITS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .cs_fall    (fell_v[1]),
    .cs_rise    (rose_v[1]),
    .sc_fall    (fell_v[0]),
    .load_word  (load_w),
    .shift_word (shift_w),
    .data_phase (in_data),
    .line_on    (sdata_oe),
    .tracking   (track),
    .asleep     (pdown)
  );

  adc_emu_word #(.W(RES_BITS)) u_word (
    .clk   (clk),
    .rst_n (rst_n_i),
    .load  (load_w),
    .shift (shift_w),
    .din   (sample),
    .msb   (word_msb)
  );

  assign sdata = in_data & word_msb;

endmodule

// File: rtl/adc_serial_emu_chk.sv
module adc_serial_emu_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic sdata,
  input logic sdata_oe,
  input logic track,
  input logic pdown
);

  // R2: a chip-select fall yields the start-of-frame outputs
  a_r2_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n) && !cs_n) |=> (sdata_oe && !pdown && track && !sdata));

  // R6: a chip-select rise always returns to idle
  a_r6_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cs_n) && cs_n) |=> (!sdata_oe && pdown && !track && !sdata));

  // R9: chip select high means powered down, line released
  a_r9_cs_high_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> (pdown && !sdata_oe));

  // R3: outputs move only when a framing input had an edge
  a_r3_quiet_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sclk) == $past(sclk, 2)) && ($past(cs_n) == $past(cs_n, 2)))
      |-> ($stable(sdata) && $stable(sdata_oe) && $stable(track) && $stable(pdown)));

  // R4: track mode is entered only by a frame start
  a_r4_track_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(track) |-> ($past(cs_n, 2) && !$past(cs_n)));

  // R5: the line is released only by a clock fall or a chip-select rise
  a_r5_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdata_oe) |-> ($past(cs_n) || ($past(sclk, 2) && !$past(sclk))));

  // R11: no data bit while the line is released
  a_r11_idle_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> !sdata);

endmodule

bind adc_serial_emu adc_serial_emu_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .sdata    (sdata),
  .sdata_oe (sdata_oe),
  .track    (track),
  .pdown    (pdown)
);

// File: tb/sim_adc_serial_emu.sv
module sim_adc_serial_emu;

  localparam int RESV [3] = '{12, 8, 10};

  logic        clk = 1'b0;
  logic        rst_n, cs_n, sclk;
  logic [11:0] sample;
  logic        so [3];
  logic        oe [3];
  logic        tr [3];
  logic        pd [3];

  int total = 0;
  int bad   = 0;
  bit chk_on = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  adc_serial_emu #(.RES_BITS(12)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample(sample),
    .sdata(so[0]), .sdata_oe(oe[0]), .track(tr[0]), .pdown(pd[0]));
  adc_serial_emu #(.RES_BITS(8)) u1 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample(sample[7:0]),
    .sdata(so[1]), .sdata_oe(oe[1]), .track(tr[1]), .pdown(pd[1]));
  adc_serial_emu #(.RES_BITS(10)) u2 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample(sample[9:0]),
    .sdata(so[2]), .sdata_oe(oe[2]), .track(tr[2]), .pdown(pd[2]));

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model: phase 0 idle, 1 running, 2 finished
  int          m_ph [3];
  int          m_nf [3];
  logic [11:0] m_wd [3];
  logic        e_so [3];
  logic        e_oe [3];
  logic        e_tr [3];
  logic        e_pd [3];
  logic        p_cs, p_sc;
  bit          ev_csf, ev_csr, ev_scf;

  always @(posedge clk) begin
    if (!rst_n) begin
      p_cs = 1'b1;
      p_sc = 1'b1;
      for (int m = 0; m < 3; m++) begin
        m_ph[m] = 0; m_nf[m] = 0; m_wd[m] = '0;
      end
    end else begin
      ev_csf = p_cs && !cs_n;
      ev_csr = !p_cs && cs_n;
      ev_scf = p_sc && !sclk;
      for (int m = 0; m < 3; m++) begin
        if (m_ph[m] == 0) begin
          if (ev_csf) begin m_ph[m] = 1; m_nf[m] = 0; end
        end else if (m_ph[m] == 1) begin
          if (ev_csr) m_ph[m] = 0;
          else if (ev_scf) begin
            m_nf[m] = m_nf[m] + 1;
            if (m_nf[m] == 3) m_wd[m] = sample & 12'((1 << RESV[m]) - 1);
            if (m_nf[m] == RESV[m] + 4) m_ph[m] = 2;
          end
        end else begin
          if (ev_csr) m_ph[m] = 0;
        end
      end
      p_cs = cs_n;
      p_sc = sclk;
    end
    for (int m = 0; m < 3; m++) begin
      e_oe[m] = (m_ph[m] == 1);
      e_pd[m] = (m_ph[m] != 1);
      e_tr[m] = (m_ph[m] == 1) && (m_nf[m] < 3);
      e_so[m] = ((m_ph[m] == 1) && (m_nf[m] >= 4)) ? m_wd[m][RESV[m] - 1 - (m_nf[m] - 4)] : 1'b0;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      for (int m = 0; m < 3; m++) begin
        chk($sformatf("%s model sdata u%0d", e_oe[m] ? "R3" : "R11", m), so[m], e_so[m]);
        chk($sformatf("R5 model sdata_oe u%0d", m), oe[m], e_oe[m]);
        chk($sformatf("R9 model pdown u%0d", m), pd[m], e_pd[m]);
        chk($sformatf("R4 model track u%0d", m), tr[m], e_tr[m]);
      end
    end
  end

  task automatic step(); @(negedge clk); endtask
  task automatic sc_low();  @(negedge clk); sclk = 1'b0; @(negedge clk); endtask
  task automatic sc_high(); @(negedge clk); sclk = 1'b1; @(negedge clk); endtask
  task automatic cs_low();  @(negedge clk); cs_n = 1'b0; @(negedge clk); endtask
  task automatic cs_high(); @(negedge clk); cs_n = 1'b1; @(negedge clk); endtask

  task automatic idle_all(input string tag);
    for (int m = 0; m < 3; m++) begin
      chk($sformatf("%s oe u%0d", tag, m), oe[m], 1'b0);
      chk($sformatf("%s pdown u%0d", tag, m), pd[m], 1'b1);
      chk($sformatf("%s track u%0d", tag, m), tr[m], 1'b0);
      chk($sformatf("%s sdata u%0d", tag, m), so[m], 1'b0);
    end
  endtask

  // abort_at: 0 = none, k>0 = chip select rises with the k-th sclk fall,
  // -1 = chip select rises before any sclk fall
  task automatic frame(input logic [11:0] w, input int abort_at, input bit swap);
    sample = w;
    cs_low();
    chk("R2 oe after cs fall", oe[0], 1'b1);
    chk("R2 pdown after cs fall", pd[0], 1'b0);
    chk("R2 track after cs fall", tr[0], 1'b1);
    chk("R2 first lead zero", so[0], 1'b0);
    if (abort_at == -1) begin
      cs_high();
      idle_all("R6 abort before clocks");
      return;
    end
    for (int k = 1; k <= 16; k++) begin
      if (k == abort_at) begin
        @(negedge clk); cs_n = 1'b1; sclk = 1'b0;
        @(negedge clk);
        idle_all("R6 abort with sclk fall");
        sc_high();
        return;
      end
      sc_low();
      if (k < 16) chk($sformatf("R3 bit %0d", k), so[0], (k < 4) ? 1'b0 : w[11 - (k - 4)]);
      if (k == 2) chk("R4 track before edge 3", tr[0], 1'b1);
      if (k == 3) chk("R4 hold at edge 3", tr[0], 1'b0);
      for (int m = 0; m < 3; m++)
        chk($sformatf("R10 oe u%0d edge %0d", m, k), oe[m], (k < RESV[m] + 4) ? 1'b1 : 1'b0);
      if (k == 16) chk("R5 pdown at end", pd[0], 1'b1);
      if (swap && k == 3) sample = ~w;
      sc_high();
    end
    for (int x = 0; x < 3; x++) begin
      sc_low();
      sc_high();
    end
    idle_all("R7 after frame");
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; sample = '0;
    repeat (4) step();
    rst_n = 1'b1;
    repeat (4) step();
    chk_on = 1'b1;
    idle_all("R1 reset");

    frame(12'hA5C, 0, 1'b0);
    cs_high();
    chk("R9 pdown cs high", pd[0], 1'b1);
    frame(12'h3C9, 0, 1'b1);          // R8 sample changed after edge 3
    cs_high();
    frame(12'hFFF, 0, 1'b0);
    cs_high();
    frame(12'h000, 0, 1'b0);
    cs_high();
    frame(12'h801, 7, 1'b0);          // R6 abort mid-result
    frame(12'h555, 2, 1'b0);          // R6 abort during leading zeros
    frame(12'h6B3, -1, 1'b0);         // R6 abort before any edge
    frame(12'h96A, 16, 1'b0);         // R6 abort on the final edge
    frame(12'hC3F, 0, 1'b0);          // recovery after aborts
    // R7: clock falls with cs low after the frame started nothing; now rearm
    cs_high();
    cs_low();
    chk("R7 new frame after cs high-low", oe[0], 1'b1);
    cs_high();
    repeat (4) step();

    chk_on = 1'b0;
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200_000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog run hung act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule